// File: doc/BRIEF.md
# MDIO Management Master

This block is the master side of a two-wire PHY management bus. It divides the system clock down to a management clock and shifts out clause-22 read and write frames, one per command, toward internal or external PHYs. Software or a configuration engine controls it through two 16-bit registers. The command register carries the target PHY address, the target register address, the transfer direction and a busy flag that can only be read. The data register carries the value to be written, or it receives the value returned by a read.

A frame starts when the command register is written while no frame is in progress. The busy flag stays set until the frame has finished. Then a one-cycle done pulse marks completion, and for a read the data register holds the returned value. The serial line is driven through a separate output and output enable, so the pad or the integrating logic builds the three-state driver. The line is released whenever the master is not driving it, and an external pull-up holds it high. The block has no streaming data path: every pin is a plain control or status signal, and there is no back-pressure.

Top module: `mdio_master`

## Requirements
- R1: After reset the command register reads 0 (busy bit 15 low), the data register reads 0, and mdc, mdio_oe and done are low.
- R2: While a frame runs, mdc has a period of MDC_DIV system clocks, with MDC_DIV/2 clocks high and MDC_DIV/2 clocks low (20 clocks by default: 2.5 MHz from 50 MHz). While idle, mdc is held low.
- R3: Each frame is 64 bits, sampled by the PHY on rising mdc. It starts with 32 ones and then the start pattern 0,1. Next comes the opcode: 1,0 for a read and 0,1 for a write. Then the 5-bit PHY address and the 5-bit register address, each msb first.
- R4: On a write, the master drives the turnaround as 1 then 0, followed by the 16 data bits msb first. mdio_oe is high for all 64 bits.
- R5: On a read, mdio_oe is low from bit 46, the first turnaround bit, through bit 63. The 16 bits on mdio_in at the last 16 rising mdc edges are loaded msb first into the data register when the frame ends.
- R6: mdio_oe is low whenever no frame is in progress.
- R7: A host write with reg_sel=0 while idle starts a frame. Its data fields are register address [4:0], PHY address [9:5], and direction [10] (1 = write, 0 = read). Busy (command register bit 15) reads high from the next cycle.
- R8: Each frame has exactly 64 rising mdc edges. In the cycle after the falling mdc edge that ends bit 63, busy reads low and done is high for exactly one cycle.
- R9: While busy is set, host writes to the command register (reg_sel=0) and to the data register (reg_sel=1) are ignored, and the frame in progress continues unchanged.
- R10: mdio_out and mdio_oe change only when mdc falls, never while mdc is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_sel | input | 1 | Register select: 0 command, 1 data |
| reg_wdata | input | 16 | Host write value |
| cmd_q | output | 16 | Command register readback, busy in bit 15 |
| data_q | output | 16 | Data register readback |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Serial data driven by the master |
| mdio_oe | output | 1 | Output enable for mdio_out |
| mdio_in | input | 1 | Serial data observed on the line |
| done | output | 1 | One-cycle frame completion pulse |

## Verification
The hardest situation to reach is a host write that lands in the middle of a read frame, after the master has released the line and while the PHY model is driving returned bits. The bench starts a read and waits about fifty management-clock periods before it writes both registers with conflicting values. It then confirms that the readback does not move, that the captured frame matches the original command, and that the PHY's value still lands in the data register. A bus model answers reads on falling mdc by counting rising edges, so the handover at the turnaround is exercised against an independent count.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = 64;
  localparam int TA_IDX     = 46;            // first turnaround bit
  localparam int DATA_IDX   = TA_IDX + 2;    // first data bit
  localparam int IDX_W      = $clog2(FRAME_BITS);

  // command register field positions
  localparam int CMD_REG_LSB = 0;
  localparam int CMD_PHY_LSB = 5;
  localparam int CMD_WR_BIT  = 10;
  localparam int CMD_BUSY    = 15;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
  } mdio_cmd_t;

  function automatic mdio_cmd_t decode_cmd(input logic [DATA_W-1:0] w);
    mdio_cmd_t c;
    c.wr    = w[CMD_WR_BIT];
    c.phy   = w[CMD_PHY_LSB +: ADDR_W];
    c.regad = w[CMD_REG_LSB +: ADDR_W];
    return c;
  endfunction

  // serial image of a frame, bit 63 goes out first
  function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_cmd_t c,
                                                        input logic [DATA_W-1:0] wd);
    logic [1:0] op;
    logic [1:0] ta;
    logic [DATA_W-1:0] pay;
    op  = c.wr ? 2'b01 : 2'b10;
    ta  = c.wr ? 2'b10 : 2'b00;
    pay = c.wr ? wd : '0;
    return {{PRE_BITS{1'b1}}, 2'b01, op, c.phy, c.regad, ta, pay};
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_oe(input mdio_cmd_t c);
    logic [FRAME_BITS-1:0] m;
    for (int i = 0; i < FRAME_BITS; i++)
      m[FRAME_BITS-1-i] = c.wr || (i < TA_IDX);
    return m;
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int MDC_DIV = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int HALF = MDC_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          at_end;

  assign at_end    = run && (cnt == CW'(HALF - 1));
  assign rise_tick = at_end && !mdc;
  assign fall_tick = at_end && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (at_end) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mdio_cmd_t         start_cmd,
  input  logic [DATA_W-1:0] start_wdata,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_in,
  output logic              mdio_out,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rx_data,
  output logic              frame_end
);
  logic                  active;
  logic [IDX_W-1:0]      idx;
  logic [FRAME_BITS-1:0] tx_sh;
  logic [FRAME_BITS-1:0] oe_sh;

  assign frame_end = active && fall_tick && (idx == IDX_W'(FRAME_BITS - 1));
  assign mdio_out  = tx_sh[FRAME_BITS-1];
  assign mdio_oe   = oe_sh[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      tx_sh  <= '0;
      oe_sh  <= '0;
    end else if (start) begin
      active <= 1'b1;
      idx    <= '0;
      tx_sh  <= build_frame(start_cmd, start_wdata);
      oe_sh  <= build_oe(start_cmd);
    end else if (active && fall_tick) begin
      if (frame_end) begin
        active <= 1'b0;
        tx_sh  <= '0;
        oe_sh  <= '0;
      end else begin
        idx    <= idx + 1'b1;
        tx_sh  <= {tx_sh[FRAME_BITS-2:0], 1'b0};
        oe_sh  <= {oe_sh[FRAME_BITS-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rx_data <= '0;
    else if (active && rise_tick && (idx >= IDX_W'(DATA_IDX)))
      rx_data <= {rx_data[DATA_W-2:0], mdio_in};
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              frame_end,
  input  logic [DATA_W-1:0] rx_data,
  output logic              start,
  output mdio_cmd_t         start_cmd,
  output logic              busy,
  output logic [DATA_W-1:0] cmd_q,
  output logic [DATA_W-1:0] data_q,
  output logic              done
);
  mdio_cmd_t cmd_r;

  assign start     = reg_wr && !reg_sel && !busy;
  assign start_cmd = decode_cmd(reg_wdata);

  always_comb begin
    cmd_q                               = '0;
    cmd_q[CMD_REG_LSB +: ADDR_W]        = cmd_r.regad;
    cmd_q[CMD_PHY_LSB +: ADDR_W]        = cmd_r.phy;
    cmd_q[CMD_WR_BIT]                   = cmd_r.wr;
    cmd_q[CMD_BUSY]                     = busy;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_r  <= '0;
      busy   <= 1'b0;
      data_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= frame_end;
      if (start) begin
        cmd_r <= start_cmd;
        busy  <= 1'b1;
      end else if (frame_end) begin
        busy  <= 1'b0;
      end
      if (reg_wr && reg_sel && !busy)
        data_q <= reg_wdata;
      else if (frame_end && !cmd_r.wr)
        data_q <= rx_data;
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int MDC_DIV = 20   // system clocks per mdc period, even
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] cmd_q,
  output logic [15:0] data_q,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in,
  output logic        done
);
  logic              start;
  mdio_cmd_t         start_cmd;
  logic              busy;
  logic              rise_tick;
  logic              fall_tick;
  logic              frame_end;
  logic [DATA_W-1:0] rx_data;

  mdio_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .frame_end (frame_end),
    .rx_data   (rx_data),
    .start     (start),
    .start_cmd (start_cmd),
    .busy      (busy),
    .cmd_q     (cmd_q),
    .data_q    (data_q),
    .done      (done)
  );

  mdio_clkgen #(.MDC_DIV(MDC_DIV)) u_clk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_cmd   (start_cmd),
    .start_wdata (data_q),
    .rise_tick   (rise_tick),
    .fall_tick   (fall_tick),
    .mdio_in     (mdio_in),
    .mdio_out    (mdio_out),
    .mdio_oe     (mdio_oe),
    .rx_data     (rx_data),
    .frame_end   (frame_end)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_sel,
  input logic [15:0] cmd_q,
  input logic [15:0] data_q,
  input logic        mdc,
  input logic        mdio_out,
  input logic        mdio_oe,
  input logic        done
);
  logic busy;
  assign busy = cmd_q[15];

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe); // R6

  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R8

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel && !busy) |=> busy); // R7

  AST_DATA_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel && busy && cmd_q[10]) |=> $stable(data_q)); // R9

  AST_CMD_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel && busy && $past(busy)) |=> $stable(cmd_q[10:0])); // R9

  AST_MDIO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_out) && $stable(mdio_oe))); // R10
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_sel  (reg_sel),
  .cmd_q    (cmd_q),
  .data_q   (data_q),
  .mdc      (mdc),
  .mdio_out (mdio_out),
  .mdio_oe  (mdio_oe),
  .done     (done)
);

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
  localparam int DIV = 20;
  localparam int NV  = 4;
  // {write, phy, reg, payload}: payload is write data or the PHY's reply
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 5'd1,  5'd0,  16'hA5C3},
    {1'b0, 5'd31, 5'd31, 16'h8001},
    {1'b1, 5'd16, 5'd21, 16'hFFFF},
    {1'b0, 5'd0,  5'd2,  16'h0000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] cmd_q, data_q;
  logic mdc, mdio_out, mdio_oe, mdio_in, done;

  int errors = 0, checks = 0;
  int rcnt = 0;
  logic [63:0] cap_out, cap_oe;
  logic [15:0] phy_reply = '0;
  logic phy_en = 1'b0, phy_bit = 1'b1;
  realtime t_rise = 0, t_prev_rise = 0, t_fall = 0, period = 0, high_t = 0;

  always #10 clk = ~clk;

  mdio_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cmd_q(cmd_q), .data_q(data_q), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in), .done(done)
  );

  assign mdio_in = mdio_oe ? mdio_out : (phy_en ? phy_bit : 1'b1);

  always @(posedge mdc) begin
    if (rcnt < 64) begin
      cap_out[63-rcnt] = mdio_out;
      cap_oe[63-rcnt]  = mdio_oe;
    end
    rcnt = rcnt + 1;
    t_prev_rise = t_rise;
    t_rise = $realtime;
    if (rcnt > 1) period = t_rise - t_prev_rise;
  end

  always @(negedge mdc) begin
    t_fall = $realtime;
    high_t = t_fall - t_rise;
    if (rcnt == 47) begin phy_en = 1'b1; phy_bit = 1'b0; end
    else if (rcnt >= 48 && rcnt < 64) begin phy_en = 1'b1; phy_bit = phy_reply[63-rcnt]; end
    else phy_en = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic host_write(input logic sel, input logic [15:0] val);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_done(output int cyc, output logic busy_at_done);
    cyc = 0;
    busy_at_done = 1'b1;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    busy_at_done = cmd_q[15];
  endtask

  function automatic logic [63:0] exp_frame(input logic w, input logic [4:0] p,
                                            input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (w ? 2'b01 : 2'b10), p, r,
            (w ? 2'b10 : 2'b00), (w ? d : 16'h0)};
  endfunction

  task automatic run_check(input logic w, input logic [4:0] p, input logic [4:0] r,
                           input logic [15:0] pay, input string tag);
    logic [63:0] ef, eoe;
    int cyc;
    logic bd;
    ef  = exp_frame(w, p, r, pay);
    eoe = w ? 64'hFFFF_FFFF_FFFF_FFFF : {{46{1'b1}}, 18'h0};
    wait_done(cyc, bd);
    chk(done === 1'b1, "R8", {tag, " done seen"}, 64'(done), 64'd1);
    chk(bd === 1'b0, "R8", {tag, " busy low with done"}, 64'(bd), 64'd0);
    chk(rcnt == 64, "R8", {tag, " rising edges"}, 64'(rcnt), 64'd64);
    @(negedge clk);
    chk(done === 1'b0, "R8", {tag, " done one cycle"}, 64'(done), 64'd0);
    chk(cap_out[63:18] === ef[63:18], "R3", {tag, " header"}, cap_out, ef);
    chk(cap_oe === eoe, w ? "R4" : "R5", {tag, " enable map"}, cap_oe, eoe);
    if (w)
      chk(cap_out[17:0] === ef[17:0], "R4", {tag, " turnaround+data"}, cap_out, ef);
    else
      chk(data_q === pay, "R5", {tag, " read data"}, 64'(data_q), 64'(pay));
    chk(period == DIV*20 && high_t == (DIV/2)*20, "R2", {tag, " mdc timing"},
        64'(int'(period)), 64'(DIV*20));
    chk(mdio_oe === 1'b0 && mdc === 1'b0, "R6", {tag, " idle release"},
        64'({mdio_oe, mdc}), 64'd0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(cmd_q === 16'h0 && data_q === 16'h0, "R1", "reset regs", 64'({cmd_q, data_q}), 64'd0);
    chk(mdc === 1'b0 && mdio_oe === 1'b0 && done === 1'b0, "R1", "reset pins",
        64'({mdc, mdio_oe, done}), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic w; logic [4:0] p, r; logic [15:0] pay;
      {w, p, r, pay} = VEC[i];
      host_write(1'b1, w ? pay : 16'h5A5A);
      phy_reply = pay;
      rcnt = 0;
      host_write(1'b0, {5'd0, w, p, r});
      chk(cmd_q === {1'b1, 4'd0, w, p, r}, "R7", "busy and fields",
          64'(cmd_q), 64'({1'b1, 4'd0, w, p, r}));
      run_check(w, p, r, pay, $sformatf("vec%0d", i));
      repeat (5) @(negedge clk);
    end

    // R9: conflicting writes in the middle of a read frame
    host_write(1'b1, 16'h0F0F);
    phy_reply = 16'hC3A5;
    rcnt = 0;
    host_write(1'b0, {5'd0, 1'b0, 5'd9, 5'd6});
    repeat (DIV * 50) @(negedge clk);
    host_write(1'b0, {5'd0, 1'b1, 5'd3, 5'd4});
    host_write(1'b1, 16'h1234);
    chk(cmd_q === {1'b1, 4'd0, 1'b0, 5'd9, 5'd6}, "R9", "cmd unchanged while busy",
        64'(cmd_q), 64'({1'b1, 4'd0, 1'b0, 5'd9, 5'd6}));
    chk(data_q === 16'h0F0F, "R9", "data unchanged while busy", 64'(data_q), 64'h0F0F);
    run_check(1'b0, 5'd9, 5'd6, 16'hC3A5, "R9 busy-write");

    // R2 idle: mdc stays low with nothing requested
    begin
      int toggles = 0;
      for (int k = 0; k < 3 * DIV; k++) begin
        @(negedge clk);
        if (mdc !== 1'b0) toggles++;
      end
      chk(toggles == 0, "R2", "mdc idle low", 64'(toggles), 64'd0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule